// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Frame-Check Flag

This block recovers characters from an asynchronous serial line. A frame is a low start bit, eight data bits sent least significant bit first, an optional ninth bit, and a high stop bit. The 10-bit or 11-bit format is picked by `nine_bit_mode`. The line is oversampled by a baud tick that pulses sixteen times per bit. Each bit is decided by a majority vote of the samples at tick counts 7, 8 and 9 within the bit period.

An optional stop-bit check can be switched on with `stop_chk_en`. It does two things. First, it raises a sticky error flag when a stop bit samples low. Second, it delays the completion flag from the last data bit to the stop bit. Software clears both flags with single-cycle strobes. When a set and a clear fall in the same cycle, the set wins.

The controller has five states: IDLE, START, DATA, NINTH and STOP. Its transitions are:
- IDLE to START on a falling edge of the line while enabled.
- START to IDLE if the start bit votes high (false start).
- START to DATA at the end of the start bit.
- DATA to NINTH (11-bit format) or DATA to STOP (10-bit format) after the eighth data bit ends.
- NINTH to STOP at the end of the ninth bit.
- STOP to IDLE as soon as the stop bit has been voted.
- Any active state to IDLE when `rx_enable` is low.

Top module: `serial_rx_fc`

## Requirements
- R1: After reset, `rx_data`, `rx_bit9`, `rx_done` and `frame_err` are all 0, and the receiver is idle.
- R2: A 10-bit frame presents its eight data bits on `rx_data` (the first bit received lands in bit 0) and sets `rx_done`. `rx_data` changes only in a cycle where `rx_done` is set.
- R3: In the 11-bit format (`nine_bit_mode`=1), the bit that follows the eighth data bit is presented on `rx_bit9`. In the 10-bit format, `rx_bit9` reads 0.
- R4: Each bit is the majority of the samples at oversampling tick counts 7, 8 and 9 of its period (counts 0 to 15 from the bit's first tick). A single wrong sample among the three does not change the bit.
- R5: A falling edge starts a frame. If the start bit votes high, the frame is dropped, the receiver returns to IDLE, and `rx_done` is not set.
- R6: With `stop_chk_en`=1, a stop bit that votes 0 sets `frame_err`, in both the 10-bit and 11-bit formats. With `stop_chk_en`=0, a low stop bit leaves `frame_err` at 0.
- R7: `frame_err` stays set through later frames with valid stop bits. It is cleared only by `clr_err` or by reset.
- R8: With `stop_chk_en`=0, `rx_done` rises after the vote of the last data bit, before the stop bit. With `stop_chk_en`=1, it rises only after the stop-bit vote.
- R9: While `rx_enable` is 0, the line is ignored. Dropping it mid-frame abandons the frame without setting `rx_done`.
- R10: `rx_done` holds until `clr_done` pulses. `rx_data` keeps its value after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| os_tick | input | 1 | One-cycle pulse, 16 per bit period |
| nine_bit_mode | input | 1 | 0: 10-bit frame, 1: 11-bit frame |
| rx_enable | input | 1 | Receiver enable |
| stop_chk_en | input | 1 | Enables stop-bit check and stop-bit completion |
| clr_done | input | 1 | Clears `rx_done` |
| clr_err | input | 1 | Clears `frame_err` |
| rx_data | output | 8 | Last received byte |
| rx_bit9 | output | 1 | Ninth bit of last frame (0 in 10-bit format) |
| rx_done | output | 1 | Receive-complete flag |
| frame_err | output | 1 | Sticky stop-bit error flag |

## Verification
A tick counter that drifts from the bit boundaries shows up within one frame as a shifted byte, because every data bit lands one position off. A sample taken at the wrong tick shows up when the bench corrupts exactly one of the three voting samples. A controller that stays out of IDLE after a false start or after an enable drop loses the next good frame. The scoreboard flags that frame at its completion. A flag that clears when it should be sticky, or a completion raised at the wrong bit, is caught by checks sampled at a fixed tick inside the stop bit. These checks run in the same frame as the fault.

// File: rtl/serial_rx_fc_pkg.sv
package serial_rx_fc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_NINTH = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

endpackage

// File: rtl/serial_rx_fc_edge.sv
// Input synchroniser with falling-edge detection on the synchronised line.
module serial_rx_fc_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= line_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[STAGES-2:0], line_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign line_s = sync_q[STAGES-1];
    assign fall   = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/serial_rx_fc_vote.sv
// Bit-period tick counter with three-sample majority vote around mid-bit.
module serial_rx_fc_vote #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic os_tick,
    input  logic line_s,
    output logic bit_ok,
    output logic bit_val,
    output logic bit_end
);
    localparam int CW     = $clog2(OSR);
    localparam int SMP_A  = OSR / 2 - 1;
    localparam int SMP_B  = OSR / 2;
    localparam int SMP_C  = OSR / 2 + 1;
    localparam int LAST_T = OSR - 1;

    logic [CW-1:0] cnt_q;
    logic          smp_a_q;
    logic          smp_b_q;
    logic          vote;

    assign vote = (smp_a_q & smp_b_q) | (smp_a_q & line_s) | (smp_b_q & line_s);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            smp_a_q <= 1'b1;
            smp_b_q <= 1'b1;
            bit_ok  <= 1'b0;
            bit_val <= 1'b1;
            bit_end <= 1'b0;
        end else begin
            bit_ok  <= 1'b0;
            bit_end <= 1'b0;
            if (!run) begin
                cnt_q <= '0;
            end else if (os_tick) begin
                if (cnt_q == LAST_T[CW-1:0]) cnt_q <= '0;
                else                         cnt_q <= cnt_q + 1'b1;
                if (cnt_q == SMP_A[CW-1:0]) smp_a_q <= line_s;
                if (cnt_q == SMP_B[CW-1:0]) smp_b_q <= line_s;
                if (cnt_q == SMP_C[CW-1:0]) begin
                    bit_ok  <= 1'b1;
                    bit_val <= vote;
                end
                if (cnt_q == LAST_T[CW-1:0]) bit_end <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_rx_fc.sv
module serial_rx_fc
    import serial_rx_fc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              os_tick,
    input  logic              nine_bit_mode,
    input  logic              rx_enable,
    input  logic              stop_chk_en,
    input  logic              clr_done,
    input  logic              clr_err,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_done,
    output logic              frame_err
);
    localparam int IW       = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int LAST_IDX = DATA_W - 1;

    rx_state_e         state_q, state_d;
    logic              line_s, fall;
    logic              bit_ok, bit_val, bit_end;
    logic              run;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              ninth_q;
    logic              last_data;
    logic              idle_w;
    logic              set_done;
    logic [DATA_W-1:0] load_data;
    logic              load_bit9;
    logic              set_err;

    serial_rx_fc_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (rx_line),
        .line_s  (line_s),
        .fall    (fall)
    );

    serial_rx_fc_vote #(.OSR(OSR)) u_vote (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .os_tick (os_tick),
        .line_s  (line_s),
        .bit_ok  (bit_ok),
        .bit_val (bit_val),
        .bit_end (bit_end)
    );

    assign run       = (state_q != ST_IDLE) && rx_enable;
    assign last_data = (idx_q == LAST_IDX[IW-1:0]);
    assign idle_w    = (state_q == ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_enable && fall) state_d = ST_START;
            end
            ST_START: begin
                if (bit_ok && bit_val) state_d = ST_IDLE;
                else if (bit_end)      state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end && last_data)
                    state_d = nine_bit_mode ? ST_NINTH : ST_STOP;
            end
            ST_NINTH: begin
                if (bit_end) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (bit_ok) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (!rx_enable) state_d = ST_IDLE;
    end

    // Completion and error decisions
    always_comb begin
        set_done  = 1'b0;
        set_err   = 1'b0;
        load_data = shift_q;
        load_bit9 = 1'b0;
        if (rx_enable && bit_ok) begin
            unique case (state_q)
                ST_DATA: begin
                    if (last_data && !nine_bit_mode && !stop_chk_en) begin
                        set_done  = 1'b1;
                        load_data = {bit_val, shift_q[DATA_W-1:1]};
                    end
                end
                ST_NINTH: begin
                    if (!stop_chk_en) begin
                        set_done  = 1'b1;
                        load_bit9 = bit_val;
                    end
                end
                ST_STOP: begin
                    if (stop_chk_en) begin
                        set_done  = 1'b1;
                        load_bit9 = nine_bit_mode & ninth_q;
                        set_err   = ~bit_val;
                    end
                end
                default: ;
            endcase
        end
    end

    // Registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            shift_q   <= '0;
            ninth_q   <= 1'b0;
            rx_data   <= '0;
            rx_bit9   <= 1'b0;
            rx_done   <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: idx_q <= '0;
                ST_DATA: begin
                    if (bit_ok)  shift_q <= {bit_val, shift_q[DATA_W-1:1]};
                    if (bit_end) idx_q   <= idx_q + 1'b1;
                end
                ST_NINTH: begin
                    if (bit_ok) ninth_q <= bit_val;
                end
                default: ;
            endcase

            if (set_done) begin
                rx_data <= load_data;
                rx_bit9 <= load_bit9;
                rx_done <= 1'b1;
            end else if (clr_done) begin
                rx_done <= 1'b0;
            end

            if (set_err)      frame_err <= 1'b1;
            else if (clr_err) frame_err <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_rx_fc_chk.sv
module serial_rx_fc_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_enable,
    input logic              stop_chk_en,
    input logic              clr_done,
    input logic              clr_err,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_done,
    input logic              frame_err,
    input logic              in_idle
);
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !clr_err) |=> frame_err);

    p_err_needs_check_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> $past(stop_chk_en));

    p_done_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !clr_done) |=> rx_done);

    p_data_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> rx_done);

    p_disable_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> in_idle);
endmodule

bind serial_rx_fc serial_rx_fc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_enable   (rx_enable),
    .stop_chk_en (stop_chk_en),
    .clr_done    (clr_done),
    .clr_err     (clr_err),
    .rx_data     (rx_data),
    .rx_done     (rx_done),
    .frame_err   (frame_err),
    .in_idle     (idle_w)
);

// File: tb/serial_rx_fc_bench.sv
module serial_rx_fc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic       nine_bit_mode = 1'b0;
    logic       rx_enable = 1'b1;
    logic       stop_chk_en = 1'b0;
    logic       clr_done = 1'b0;
    logic       clr_err = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       rx_done;
    logic       frame_err;

    int total = 0;
    int bad = 0;
    logic [8:0] exp_q[$];

    serial_rx_fc u_serial_rx_fc (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
        .nine_bit_mode(nine_bit_mode), .rx_enable(rx_enable),
        .stop_chk_en(stop_chk_en), .clr_done(clr_done), .clr_err(clr_err),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_done(rx_done),
        .frame_err(frame_err)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (!os_tick);
        @(negedge clk);
    endtask

    task automatic drive(input logic v, input int n);
        rx_line = v;
        for (int i = 0; i < n; i++) wait_tick();
    endtask

    task automatic drive_bit(input logic v, input logic glitch);
        if (glitch) begin
            drive(v, 8);
            drive(~v, 1);
            drive(v, 7);
        end else begin
            drive(v, 16);
        end
    endtask

    task automatic pulse_clr_done();
        @(negedge clk); clr_done = 1'b1;
        @(negedge clk); clr_done = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b9, input logic stopv,
                              input logic [7:0] gmask, input bit expect_rx, input bit timing);
        pulse_clr_done();
        drive(1'b1, 4);
        if (expect_rx) exp_q.push_back({nine_bit_mode ? b9 : 1'b0, d});
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            if (timing && i == 7 && !nine_bit_mode) begin
                drive(d[i], 12);
                // R8: done before the stop bit only when the check is off
                check("R8 done after last data bit", 16'(rx_done), 16'(!stop_chk_en));
                drive(d[i], 4);
            end else begin
                drive_bit(d[i], gmask[i]);
            end
        end
        if (nine_bit_mode) drive_bit(b9, 1'b0);
        drive(stopv, 12);
        if (timing) check("R8 done after stop vote", 16'(rx_done), 16'h1);
        drive(stopv, 4);
        drive(1'b1, 4);
    endtask

    // Scoreboard monitor
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && rx_done && !prev) begin
                if (exp_q.size() == 0) begin
                    check("R5/R9 unexpected completion", 16'(rx_data), 16'hffff);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    check("R2 data", 16'(rx_data), 16'(e[7:0]));
                    check("R3 ninth bit", 16'(rx_bit9), 16'(e[8]));
                end
            end
            prev = rx_done;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1 data", 16'(rx_data), 16'h0);
        check("R1 bit9", 16'(rx_bit9), 16'h0);
        check("R1 done", 16'(rx_done), 16'h0);
        check("R1 err", 16'(frame_err), 16'h0);
        rst_n = 1'b1;
        drive(1'b1, 4);

        // R2 basic 10-bit frames, R8 timing with check off
        send_frame(8'hA5, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0);
        send_frame(8'h3C, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1);
        check("R2 done set", 16'(rx_done), 16'h1);

        // R10 clear keeps data
        pulse_clr_done();
        check("R10 done cleared", 16'(rx_done), 16'h0);
        check("R10 data held", 16'(rx_data), 16'h3C);

        // R4 single corrupted vote sample on several bits
        send_frame(8'h96, 1'b0, 1'b1, 8'hF3, 1'b1, 1'b0);

        // R3 11-bit frames
        nine_bit_mode = 1'b1;
        send_frame(8'h5A, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0);
        check("R3 ninth bit high", 16'(rx_bit9), 16'h1);
        send_frame(8'hC3, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0);
        nine_bit_mode = 1'b0;
        send_frame(8'hFF, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0);
        check("R3 ten-bit bit9 zero", 16'(rx_bit9), 16'h0);

        // R6 check off: low stop gives no error
        send_frame(8'h11, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R6 no error when check off", 16'(frame_err), 16'h0);

        // R6/R8 check on, 10-bit
        stop_chk_en = 1'b1;
        send_frame(8'h42, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1);
        check("R6 good stop no error", 16'(frame_err), 16'h0);
        send_frame(8'h24, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R6 bad stop sets error", 16'(frame_err), 16'h1);
        // R7 sticky
        send_frame(8'h81, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0);
        check("R7 error survives good frame", 16'(frame_err), 16'h1);
        @(negedge clk); clr_err = 1'b1;
        @(negedge clk); clr_err = 1'b0;
        check("R7 error cleared", 16'(frame_err), 16'h0);
        // R6 11-bit format
        nine_bit_mode = 1'b1;
        send_frame(8'h7E, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R6 bad stop 11-bit", 16'(frame_err), 16'h1);
        @(negedge clk); clr_err = 1'b1;
        @(negedge clk); clr_err = 1'b0;
        nine_bit_mode = 1'b0;
        stop_chk_en = 1'b0;

        // R5 false start
        pulse_clr_done();
        drive(1'b0, 6);
        drive(1'b1, 40);
        check("R5 no completion", 16'(rx_done), 16'h0);
        send_frame(8'h69, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0);

        // R9 disabled: whole frame ignored
        rx_enable = 1'b0;
        send_frame(8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
        check("R9 disabled ignored", 16'(rx_done), 16'h0);
        rx_enable = 1'b1;

        // R9 drop mid-frame
        pulse_clr_done();
        drive(1'b1, 4);
        drive_bit(1'b0, 1'b0);
        drive_bit(1'b1, 1'b0);
        drive_bit(1'b0, 1'b0);
        rx_enable = 1'b0;
        for (int i = 0; i < 6; i++) drive_bit(i[0], 1'b0);
        drive(1'b1, 20);
        check("R9 abandoned frame", 16'(rx_done), 16'h0);
        rx_enable = 1'b1;
        drive(1'b1, 4);
        send_frame(8'hB4, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0);
        check("R9 recovers", 16'(rx_data), 16'hB4);

        check("scoreboard drained", 16'(exp_q.size()), 16'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule